// File: doc/BRIEF.md
# DDR SDRAM Access and Refresh Command Scheduler

This block turns single read or write requests from a user port into DDR SDRAM command sequences, and it adds periodic refresh. Once the memory has been initialised, an accepted request produces an ACTIVE command that carries the row and bank. After the RAS-to-CAS wait, a READ or WRITE with auto-precharge follows and carries the column. The block then counts out the CAS latency, the burst data phase and, for writes, the recovery-plus-precharge time before it returns to idle. There is never an open row to track.

An internal interval counter raises a refresh request at a fixed period, chosen by a parameter. When a refresh request is pending in idle, it is served before any user request with an AUTO_REFRESH command and a recovery wait. The 24-bit system address is split into a row field (bits 23..12), a bank field (bits 11..10) and a column field (bits 9..0). Strobes mark the cycles in which read data returns and write data must be driven. The I/O cells and the data capture are outside this block.

Top module: `ddr_cmd_sched`

## Requirements
- R1: While reset is held and right after it, the command output is NOP (4'b0111), ack is 0, both data strobes are 0 and the address and bank outputs are 0.
- R2: While init_done is 0, requests are ignored: the command stays NOP and ack stays 0. The refresh interval counter does not advance.
- R3: A request seen in idle with init_done high and no refresh pending gives ACTIVE (4'b0011) in the next cycle. ack is 1 in that same cycle only, ddr_addr carries req_addr[23:12] and ddr_bank carries req_addr[11:10].
- R4: READ (4'b0101) or WRITE (4'b0100) is issued 3 cycles after ACTIVE, with two NOP cycles of RAS-to-CAS wait between them. In that cycle ddr_addr[9:0] is req_addr[9:0], ddr_addr[10] is 1 (auto-precharge), ddr_addr[11] is 0 and ddr_bank is the bank again.
- R5: After READ there are CAS-latency NOP cycles: 2 for CL2, and 3 for both CL2.5 and CL3 (default CL2.5). Then rd_phase is high for 1, 2 or 4 cycles for burst length 2, 4 or 8 (default 8).
- R6: wr_phase is high for the burst cycle count (4 at the default) starting the cycle after WRITE.
- R7: After the write data phase the block waits max(T_DAL-3, 0) cycles before idle, which is 4 cycles at the default T_DAL of 7.
- R8: No request is accepted until the block is back in idle. With req held, the next ACTIVE comes 12 cycles after the previous ACTIVE for a read and 13 cycles after it for a write. Direction and address are captured at acceptance.
- R9: With init_done high, a refresh request arises every REF_SEL-selected interval (0:750, 1:1000, 2:1500, 3:2000 clocks, default 2000). It is served from idle with AUTO_REFRESH (4'b0001). The first one is issued 2001 clocks after init_done rises, and later ones follow every 2000 clocks while the block is otherwise idle.
- R10: AUTO_REFRESH is followed by 10 NOP cycles of refresh recovery and then one idle cycle, so a held request gets its ACTIVE 12 cycles after AUTO_REFRESH.
- R11: When a refresh request and a user request are both present in idle, AUTO_REFRESH is issued with ack 0. The refresh request clears once AUTO_REFRESH is issued, and the user request is served afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Memory initialisation complete; enables scheduling and refresh timing |
| req | input | 1 | User access request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | System address: row 23..12, bank 11..10, column 9..0 |
| ack | output | 1 | Request accepted (cycle of ACTIVE) |
| cmd_n | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| ddr_addr | output | 12 | Row during ACTIVE; column plus auto-precharge bit during READ/WRITE |
| ddr_bank | output | 2 | Bank during ACTIVE and READ/WRITE |
| rd_phase | output | 1 | Read data returning this cycle |
| wr_phase | output | 1 | Write data to be driven this cycle |

## Verification
On every cycle, the assertions check the legal state orderings: READ or WRITE only straight after the RAS-to-CAS wait, refresh only out of idle, acceptance only with init_done high and no refresh pending, and no ACTIVE while busy. They also check the refresh counter's reload, its freeze before init_done and the clearing of the pending flag. The exact cycle counts (CAS wait, burst length, post-write wait, recovery after refresh, ACTIVE-to-ACTIVE spacing) and the absolute refresh period only show up in the bench's scenarios. Those scenarios follow each sequence cycle by cycle and time the refresh commands from init_done.

// File: rtl/ddr_sched_pkg.sv
`timescale 1ns/1ps
// Shared types, command encodings and parameter-decoding functions for the
// DDR command scheduler. Assumes the mode settings are fixed at elaboration.
package ddr_sched_pkg;

    // Scheduler states; encodings kept stable for any neighbour that decodes them.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'b0000,
        ST_TRCD   = 4'b0001,
        ST_CL     = 4'b0010,
        ST_RDATA  = 4'b0011,
        ST_WDATA  = 4'b0100,
        ST_TRFC   = 4'b0101,
        ST_TDAL   = 4'b0110,
        ST_ACTIVE = 4'b1000,
        ST_READA  = 4'b1001,
        ST_WRITEA = 4'b1010,
        ST_AREF   = 4'b1011
    } sched_state_e;

    // Command vector {cs_n, ras_n, cas_n, we_n}.
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_ACT  = 4'b0011;
    localparam logic [3:0] CMD_RD   = 4'b0101;
    localparam logic [3:0] CMD_WR   = 4'b0100;
    localparam logic [3:0] CMD_AREF = 4'b0001;

    // CAS latency select: 0 = CL2, 1 = CL2.5, 2 = CL3; half cycles round up.
    function automatic int cas_clocks(input int sel);
        case (sel)
            0:       return 2;
            default: return 3;
        endcase
    endfunction

    // Burst select: 0 = BL2, 1 = BL4, 2 = BL8; two beats per user-side clock.
    function automatic int burst_clocks(input int sel);
        case (sel)
            0:       return 1;
            1:       return 2;
            default: return 4;
        endcase
    endfunction

    // Refresh interval select in clocks.
    function automatic int refresh_interval(input int sel);
        case (sel)
            0:       return 750;
            1:       return 1000;
            2:       return 1500;
            default: return 2000;
        endcase
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_addr_latch.sv
`timescale 1ns/1ps
// Captures the system address at request acceptance and splits it into
// row (upper), bank (middle) and column (lower) fields.
// Assumes the address is valid in the acceptance cycle.
module ddr_addr_latch #(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [ROW_W+BANK_W+COL_W-1:0] sys_addr,
    output logic [ROW_W-1:0]              row,
    output logic [BANK_W-1:0]             bank,
    output logic [COL_W-1:0]              col
);
    localparam int BANK_LSB = COL_W;
    localparam int ROW_LSB  = COL_W + BANK_W;

    // Hold the address fields of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row  <= '0;
            bank <= '0;
            col  <= '0;
        end else if (load) begin
            row  <= sys_addr[ROW_LSB +: ROW_W];
            bank <= sys_addr[BANK_LSB +: BANK_W];
            col  <= sys_addr[0 +: COL_W];
        end
    end

    // R3/R4: fields hold until the next acceptance.
    p_fields_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(row) && $stable(bank) && $stable(col)));

endmodule

// File: rtl/ddr_refresh_timer.sv
`timescale 1ns/1ps
// Refresh interval counter. Counts only while enabled, raises a pending
// refresh flag every interval and drops it when the refresh is issued.
// Assumes the scheduler serves the flag before the next interval elapses.
module ddr_refresh_timer
    import ddr_sched_pkg::*;
#(
    parameter int REF_SEL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic issued,
    output logic pending
);
    localparam int REF_INT = refresh_interval(REF_SEL);
    localparam int CNT_W   = $clog2(REF_INT);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REF_INT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = enable && (cnt_q == '0);

    // Down-count the interval while enabled, reloading on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= RELOAD;
        else if (tick)   cnt_q <= RELOAD;
        else if (enable) cnt_q <= cnt_q - 1'b1;
    end

    // Pending flag: set on expiry, cleared once the refresh goes out.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (tick)   pending <= 1'b1;
        else if (issued) pending <= 1'b0;
    end

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == RELOAD && pending));

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt_q));

    p_pend_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && !tick) |=> !pending);

endmodule

// File: rtl/ddr_cmd_fsm.sv
`timescale 1ns/1ps
// Command sequencer: idle -> ACTIVE -> RAS-to-CAS wait -> READ/WRITE with
// auto-precharge -> CAS wait / data phase -> post-write wait -> idle, plus
// AUTO_REFRESH -> recovery -> idle. Refresh wins in idle.
// Assumes every wait parameter except T_DAL is at least 1.
module ddr_cmd_fsm
    import ddr_sched_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int CAS_CLK   = 3,
    parameter int BURST_CLK = 4,
    parameter int T_DAL     = 7,
    parameter int T_RFC     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_done,
    input  logic         req,
    input  logic         req_wr,
    input  logic         ref_pend,
    output sched_state_e state,
    output logic         accept
);
    // The idle, ACTIVE and RAS-to-CAS cycles already cover 3 clocks of T_DAL.
    localparam int DAL_WAIT = (T_DAL < 3) ? 0 : T_DAL - 3;
    localparam int CNT_MAX  = max_of(max_of(T_RCD, CAS_CLK),
                                     max_of(max_of(BURST_CLK, T_RFC), max_of(DAL_WAIT, 1)));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_CL    = CNT_W'(CAS_CLK - 1);
    localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_CLK - 1);
    localparam logic [CNT_W-1:0] LD_RFC   = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_DAL   = CNT_W'(max_of(DAL_WAIT, 1) - 1);

    sched_state_e     state_q, state_d, after_write;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q, wr_d;
    logic             wait_done;

    assign wait_done = (cnt_q == '0);
    assign state     = state_q;

    // Pick the state after the write data phase: skip the wait if it is zero.
    generate
        if (DAL_WAIT == 0) begin : g_no_dal
            assign after_write = ST_IDLE;
        end else begin : g_dal
            assign after_write = ST_TDAL;
        end
    endgenerate

    // Next-state, wait-counter and direction decisions.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wr_d    = wr_q;
        accept  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (init_done) begin
                    if (ref_pend) begin
                        state_d = ST_AREF;
                    end else if (req) begin
                        state_d = ST_ACTIVE;
                        accept  = 1'b1;
                        wr_d    = req_wr;
                    end
                end
            end
            ST_ACTIVE: begin
                state_d = ST_TRCD;
                cnt_d   = LD_RCD;
            end
            ST_TRCD: begin
                if (wait_done) state_d = wr_q ? ST_WRITEA : ST_READA;
                else           cnt_d   = cnt_q - 1'b1;
            end
            ST_READA: begin
                state_d = ST_CL;
                cnt_d   = LD_CL;
            end
            ST_CL: begin
                if (wait_done) begin
                    state_d = ST_RDATA;
                    cnt_d   = LD_BURST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RDATA: begin
                if (wait_done) state_d = ST_IDLE;
                else           cnt_d   = cnt_q - 1'b1;
            end
            ST_WRITEA: begin
                state_d = ST_WDATA;
                cnt_d   = LD_BURST;
            end
            ST_WDATA: begin
                if (wait_done) begin
                    state_d = after_write;
                    cnt_d   = LD_DAL;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TDAL: begin
                if (wait_done) state_d = ST_IDLE;
                else           cnt_d   = cnt_q - 1'b1;
            end
            ST_AREF: begin
                state_d = ST_TRFC;
                cnt_d   = LD_RFC;
            end
            ST_TRFC: begin
                if (wait_done) state_d = ST_IDLE;
                else           cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
        end
    end

    p_accept_needs_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> $past(init_done && req && !ref_pend));

    p_cas_after_trcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READA || state_q == ST_WRITEA) |-> ($past(state_q) == ST_TRCD));

    p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_ACTIVE));

    p_aref_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AREF) |-> ($past(state_q) == ST_IDLE));

    p_refresh_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && init_done && ref_pend) |=> (state_q == ST_AREF));

    p_rd_after_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && $past(state_q) != ST_RDATA) |-> ($past(state_q) == ST_CL));

endmodule

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
// Maps the scheduler state onto the command vector, the acknowledge, the
// address and bank outputs, and the data-phase strobes.
// Assumes the column fits below the auto-precharge bit.
module ddr_cmd_decode
    import ddr_sched_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  sched_state_e      state,
    input  logic [ROW_W-1:0]  row,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    output logic [3:0]        cmd_n,
    output logic              ack,
    output logic [ROW_W-1:0]  ddr_addr,
    output logic [BANK_W-1:0] ddr_bank,
    output logic              rd_phase,
    output logic              wr_phase
);
    // Per-state output decode; anything not listed drives NOP and zeros.
    always_comb begin
        cmd_n    = CMD_NOP;
        ack      = 1'b0;
        ddr_addr = '0;
        ddr_bank = '0;
        rd_phase = (state == ST_RDATA);
        wr_phase = (state == ST_WDATA);
        case (state)
            ST_ACTIVE: begin
                cmd_n    = CMD_ACT;
                ack      = 1'b1;
                ddr_addr = row;
                ddr_bank = bank;
            end
            ST_READA, ST_WRITEA: begin
                cmd_n                = (state == ST_READA) ? CMD_RD : CMD_WR;
                ddr_addr[COL_W-1:0]  = col;
                ddr_addr[AP_BIT]     = 1'b1;
                ddr_bank             = bank;
            end
            ST_AREF: cmd_n = CMD_AREF;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_cmd_sched.sv
`timescale 1ns/1ps
// Top of the DDR access and refresh command scheduler. Accepts one request
// at a time after initialisation, issues auto-precharge accesses and
// periodic auto-refresh. Assumes req and its fields are held until ack.
module ddr_cmd_sched
    import ddr_sched_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    parameter int CAS_SEL   = 1,
    parameter int BURST_SEL = 2,
    parameter int REF_SEL   = 3,
    parameter int T_RCD     = 2,
    parameter int T_DAL     = 7,
    parameter int T_RFC     = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init_done,
    input  logic                          req,
    input  logic                          req_wr,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    output logic                          ack,
    output logic [3:0]                    cmd_n,
    output logic [ROW_W-1:0]              ddr_addr,
    output logic [BANK_W-1:0]             ddr_bank,
    output logic                          rd_phase,
    output logic                          wr_phase
);
    localparam int CAS_CLK   = cas_clocks(CAS_SEL);
    localparam int BURST_CLK = burst_clocks(BURST_SEL);

    sched_state_e      state;
    logic              accept;
    logic              ref_pend;
    logic              ref_issued;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;

    assign ref_issued = (state == ST_AREF);

    ddr_refresh_timer #(.REF_SEL(REF_SEL)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (init_done),
        .issued  (ref_issued),
        .pending (ref_pend)
    );

    ddr_cmd_fsm #(
        .T_RCD     (T_RCD),
        .CAS_CLK   (CAS_CLK),
        .BURST_CLK (BURST_CLK),
        .T_DAL     (T_DAL),
        .T_RFC     (T_RFC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .req       (req),
        .req_wr    (req_wr),
        .ref_pend  (ref_pend),
        .state     (state),
        .accept    (accept)
    );

    ddr_addr_latch #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .sys_addr (req_addr),
        .row      (row),
        .bank     (bank),
        .col      (col)
    );

    ddr_cmd_decode #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dec (
        .state    (state),
        .row      (row),
        .bank     (bank),
        .col      (col),
        .cmd_n    (cmd_n),
        .ack      (ack),
        .ddr_addr (ddr_addr),
        .ddr_bank (ddr_bank),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase)
    );

    p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_phase && wr_phase));

endmodule

// File: tb/tb_ddr_cmd_sched.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_ddr_cmd_sched;
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] ACT  = 4'b0011;
    localparam logic [3:0] RD   = 4'b0101;
    localparam logic [3:0] WR   = 4'b0100;
    localparam logic [3:0] AREF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n, init_done, req, req_wr;
    logic [23:0] req_addr;
    logic        ack, rd_phase, wr_phase;
    logic [3:0]  cmd_n;
    logic [11:0] ddr_addr;
    logic [1:0]  ddr_bank;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int t_init = 0;
    int t_aref = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    ddr_cmd_sched dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .ack(ack), .cmd_n(cmd_n), .ddr_addr(ddr_addr),
        .ddr_bank(ddr_bank), .rd_phase(rd_phase), .wr_phase(wr_phase)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Starting at the negedge where ACTIVE shows, follow one access cycle by cycle.
    task automatic follow(input bit wr, input logic [23:0] a, input bit hold,
                          input bit nxt_wr, input logic [23:0] nxt_a);
        int last;
        chk("R3 ACTIVE with ack", {cmd_n, ack}, {ACT, 1'b1});
        chk("R3 row on address", ddr_addr, a[23:12]);
        chk("R3 bank", ddr_bank, a[11:10]);
        if (hold) begin
            req_wr   = nxt_wr;
            req_addr = nxt_a;
        end else begin
            req = 1'b0;
        end
        last = wr ? 12 : 11;
        for (int k = 1; k <= last; k++) begin
            logic [3:0] ce;
            logic re, we;
            string tag;
            @(negedge clk);
            ce = NOP; re = 1'b0; we = 1'b0;
            if (k < 3) tag = "R4 RAS-to-CAS NOP";
            else if (k == 3) begin
                ce = wr ? WR : RD;
                tag = "R4 READ/WRITE cmd";
                chk("R4 column with auto-precharge", ddr_addr, {2'b01, a[9:0]});
                chk("R4 bank at column", ddr_bank, a[11:10]);
            end else if (!wr) begin
                if (k <= 6) tag = "R5 CAS wait";
                else if (k <= 10) begin re = 1'b1; tag = "R5 read burst"; end
                else tag = "R8 idle, no accept";
            end else begin
                if (k <= 7) begin we = 1'b1; tag = "R6 write burst"; end
                else if (k <= 11) tag = "R7 post-write wait";
                else tag = "R8 idle, no accept";
            end
            chk(tag, {cmd_n, ack, re ? rd_phase : rd_phase, wr_phase},
                     {ce, 1'b0, re, we});
        end
        if (hold) begin
            @(negedge clk);
            chk("R8 held request ACTIVE at spacing", {cmd_n, ack}, {ACT, 1'b1});
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; init_done = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {cmd_n, ack, rd_phase, wr_phase, ddr_bank, ddr_addr},
            {NOP, 3'b000, 2'b00, 12'h000});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {cmd_n, ack, rd_phase, wr_phase}, {NOP, 3'b000});
    endtask

    task automatic t_no_init();
        req = 1'b1; req_wr = 1'b0; req_addr = 24'h123456;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R2 request ignored before init", {cmd_n, ack}, {NOP, 1'b0});
        end
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_single(input bit wr, input logic [23:0] a);
        req = 1'b1; req_wr = wr; req_addr = a;
        @(negedge clk);
        follow(wr, a, 1'b0, 1'b0, '0);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        req = 1'b1; req_wr = 1'b0; req_addr = 24'hC3F_9_2A;
        @(negedge clk);
        follow(1'b0, 24'hC3F_9_2A, 1'b1, 1'b1, 24'h5A1_7C4);
        follow(1'b1, 24'h5A1_7C4, 1'b0, 1'b0, '0);
        @(negedge clk);
    endtask

    task automatic t_first_refresh();
        int guard = 0;
        while (cmd_n !== AREF && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        t_aref = cyc;
        chk("R9 first AUTO_REFRESH time from init", t_aref - t_init, 2001);
        chk("R9 AUTO_REFRESH cmd", cmd_n, AREF);
        req = 1'b1; req_wr = 1'b0; req_addr = 24'h0F0_8_01;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            chk("R10 refresh recovery NOP", {cmd_n, ack}, {NOP, 1'b0});
        end
        @(negedge clk);
        follow(1'b0, 24'h0F0_8_01, 1'b0, 1'b0, '0);
    endtask

    task automatic t_priority();
        while (cyc < t_aref + 1999) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 24'hFFF_F_FF;
        @(negedge clk);
        chk("R11 refresh wins over request", {cmd_n, ack}, {AREF, 1'b0});
        chk("R9 refresh period", cyc - t_aref, 2000);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            chk("R10 recovery before user access", {cmd_n, ack}, {NOP, 1'b0});
        end
        @(negedge clk);
        follow(1'b1, 24'hFFF_F_FF, 1'b0, 1'b0, '0);
        repeat (3) begin
            @(negedge clk);
            chk("R11 refresh flag cleared, no extra refresh", cmd_n, NOP);
        end
    endtask

    initial begin
        t_reset();
        t_no_init();
        init_done = 1'b1;
        t_init = cyc;
        t_single(1'b0, 24'hA5C_B_F1);
        t_single(1'b1, 24'h3E2_4_0C);
        t_back_to_back();
        t_first_refresh();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule